// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This block tells the driver to fasten the seat belt. It reads three event inputs (ignition switched on, ignition switched off, belt latched) and a strobe that pulses once per second. After the ignition comes on, the block allows a grace period of `SHORT_TICKS` seconds. If the belt is still open when that period ends, the block starts an alarm. The alarm ends when the belt is latched, when the ignition is switched off, or when `LONG_TICKS` seconds have passed since the ignition came on. Both periods are measured from the same timer start.

The controller and its second counter form one synchronous product machine and update on the same clock edge. The block reports events as one-cycle pulses:

- `start_timer`: the ignition came on and the timer was started.
- `alarm_on`: the alarm began.
- `alarm_off`: the alarm ended.

A level output, `alarm`, is high for the whole time the alarm runs. Every output is registered. Input debouncing and the buzzer driver belong to other blocks.

Top module: `belt_alarm_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the block in its idle state and clears the timer. All four outputs are low in the cycle after reset.
- R2: In idle, `key_on` moves the block to the waiting state and restarts the timer at count 0. `start_timer` is high for exactly one cycle. In idle, `key_off`, `belt_on` and `tick` have no effect.
- R3: In the waiting state, `key_off` or `belt_on` returns the block to idle. No output pulse is produced.
- R4: In the waiting state, the `SHORT_TICKS`-th tick counted since the timer start moves the block to the alarm state and produces one `alarm_on` pulse. If `key_off` or `belt_on` arrives in the same cycle as that tick, the block goes to idle instead and gives no pulse.
- R5: In the alarm state, any of `belt_on`, `key_off` or the `LONG_TICKS`-th tick since the timer start returns the block to idle. Exactly one `alarm_off` pulse is produced, even when several of these arrive together.
- R6: When no transition condition holds, the state is kept and no pulse is produced. `key_on` in the waiting or alarm state is ignored and does not restart the timer.
- R7: The timer counts only ticks that arrive after the cycle in which it was started. A tick in the same cycle as the `key_on` that starts it is not counted. The count stops at `LONG_TICKS` and does not wrap.
- R8: `alarm` is high in every cycle in which the block is in the alarm state and low otherwise. It rises together with `alarm_on` and falls together with `alarm_off`.
- R9: Every output changes one clock after the edge at which the causing inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_on | input | 1 | Ignition switched on event |
| key_off | input | 1 | Ignition switched off event |
| belt_on | input | 1 | Belt latched event |
| tick | input | 1 | One-second strobe, one cycle wide |
| start_timer | output | 1 | Pulse: timer started on ignition |
| alarm_on | output | 1 | Pulse: alarm begins |
| alarm_off | output | 1 | Pulse: alarm ends |
| alarm | output | 1 | Level: alarm running |

## Verification
The hardest cases to reach are ties between a timer event and an exit input in the same cycle. One tie is the grace-period tick arriving together with the belt or ignition-off event. The other is the final tick arriving together with an exit input while the alarm runs. The stimulus reaches these ties by counting ticks from a fresh start. It then sweeps the exit input over every tick position from zero through the tie itself, in both the waiting and the alarm states. It also places a tick on the start cycle itself, and a repeated `key_on` partway through the count, to show that neither one shifts the timeout.

// File: rtl/belt_alarm_pkg.sv
package belt_alarm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ARMED    = 2'd1,
    ST_SOUNDING = 2'd2
  } belt_state_t;
endpackage

// File: rtl/belt_tick_timer.sv
module belt_tick_timer #(
  parameter int SHORT_TICKS = 5,
  parameter int LONG_TICKS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic end_short,
  output logic end_long
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] CNT_TOP    = CW'(LONG_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick && cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

  // Timer events are Mealy outputs of the counter, consumed on the same edge
  assign end_short = tick && !restart && (cnt == SHORT_LAST);
  assign end_long  = tick && !restart && (cnt == LONG_LAST);

  p_cnt_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_TOP);
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == '0);
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_TOP && !restart) |=> cnt == CNT_TOP);
endmodule

// File: rtl/belt_alarm_fsm.sv
module belt_alarm_fsm
  import belt_alarm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic key_on,
  input  logic key_off,
  input  logic belt_on,
  input  logic end_short,
  input  logic end_long,
  output logic restart,
  output logic start_q,
  output logic on_q,
  output logic off_q,
  output logic level_q
);
  belt_state_t st, nxt;
  logic go_start, go_on, go_off;

  always_comb begin
    nxt      = st;
    go_start = 1'b0;
    go_on    = 1'b0;
    go_off   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (key_on) begin
          nxt      = ST_ARMED;
          go_start = 1'b1;
        end
      end
      ST_ARMED: begin
        if (key_off || belt_on) nxt = ST_IDLE;
        else if (end_short) begin
          nxt   = ST_SOUNDING;
          go_on = 1'b1;
        end
      end
      ST_SOUNDING: begin
        if (belt_on || key_off || end_long) begin
          nxt    = ST_IDLE;
          go_off = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign restart = go_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      start_q <= 1'b0;
      on_q    <= 1'b0;
      off_q   <= 1'b0;
      level_q <= 1'b0;
    end else begin
      st      <= nxt;
      start_q <= go_start;
      on_q    <= go_on;
      off_q   <= go_off;
      level_q <= (nxt == ST_SOUNDING);
    end
  end

  p_pulses_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_q, on_q, off_q}));
  p_start_needs_key_r2: assert property (@(posedge clk) disable iff (rst)
    start_q |-> $past(key_on));
  p_level_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(level_q) |-> on_q);
  p_on_sets_level_r4: assert property (@(posedge clk) disable iff (rst)
    on_q |-> level_q);
  p_off_clears_level_r5: assert property (@(posedge clk) disable iff (rst)
    off_q |-> !level_q);
  p_level_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(level_q) |-> off_q);
endmodule

// File: rtl/belt_alarm_ctrl.sv
module belt_alarm_ctrl #(
  parameter int SHORT_TICKS = 5,
  parameter int LONG_TICKS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic key_on,
  input  logic key_off,
  input  logic belt_on,
  input  logic tick,
  output logic start_timer,
  output logic alarm_on,
  output logic alarm_off,
  output logic alarm
);
  logic restart, end_short, end_long;

  belt_tick_timer #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .tick     (tick),
    .end_short(end_short),
    .end_long (end_long)
  );

  belt_alarm_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .key_on   (key_on),
    .key_off  (key_off),
    .belt_on  (belt_on),
    .end_short(end_short),
    .end_long (end_long),
    .restart  (restart),
    .start_q  (start_timer),
    .on_q     (alarm_on),
    .off_q    (alarm_off),
    .level_q  (alarm)
  );

  initial begin
    assert (SHORT_TICKS >= 1 && SHORT_TICKS < LONG_TICKS)
      else $error("delay parameters out of order");
  end
endmodule

// File: tb/sim_belt_alarm_ctrl.sv
module sim_belt_alarm_ctrl;
  localparam int SHORT = 5;
  localparam int LONG  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_on = 0, key_off = 0, belt_on = 0, tick = 0;
  logic start_timer, alarm_on, alarm_off, alarm;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  belt_alarm_ctrl #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) u0 (
    .clk(clk), .rst(rst), .key_on(key_on), .key_off(key_off),
    .belt_on(belt_on), .tick(tick), .start_timer(start_timer),
    .alarm_on(alarm_on), .alarm_off(alarm_off), .alarm(alarm)
  );

  // exp = {start_timer, alarm_on, alarm_off, alarm}
  task automatic cyc(input logic k, input logic o, input logic b, input logic t,
                     input logic [3:0] exp, input string tag);
    key_on = k; key_off = o; belt_on = b; tick = t;
    @(posedge clk);
    @(negedge clk);
    key_on = 0; key_off = 0; belt_on = 0; tick = 0;
    checks++;
    if ({start_timer, alarm_on, alarm_off, alarm} !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag,
               {start_timer, alarm_on, alarm_off, alarm}, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    checks++;
    if ({start_timer, alarm_on, alarm_off, alarm} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 got %b exp 0000", {start_timer, alarm_on, alarm_off, alarm});
    end
  endtask

  task automatic arm();
    cyc(1, 0, 0, 0, 4'b1000, "R2 start pulse");
  endtask

  // reach alarm state: arm, then SHORT ticks
  task automatic to_alarm();
    arm();
    for (int i = 1; i < SHORT; i++) cyc(0, 0, 0, 1, 4'b0000, "R4 grace");
    cyc(0, 0, 0, 1, 4'b0101, "R4 alarm_on");
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R2/R6: idle ignores other inputs
    cyc(0, 1, 0, 0, 4'b0000, "R2 idle key_off");
    cyc(0, 0, 1, 0, 4'b0000, "R2 idle belt");
    for (int i = 0; i < LONG + 2; i++) cyc(0, 0, 0, 1, 4'b0000, "R2 idle tick");

    // full timeout path, with idle gaps between ticks
    to_alarm();
    cyc(0, 0, 0, 0, 4'b0001, "R8 hold level");
    for (int i = SHORT + 1; i < LONG; i++) begin
      cyc(0, 0, 0, 1, 4'b0001, "R8 alarm level");
      cyc(1, 0, 0, 0, 4'b0001, "R6 key_on ignored in alarm");
    end
    cyc(0, 0, 0, 1, 4'b0010, "R5 timeout alarm_off");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 4'b0000, "R9 idle after");

    // R3: exit from waiting at every tick position, both exit inputs
    for (int e = 0; e < 2; e++) begin
      for (int n = 0; n < SHORT; n++) begin
        arm();
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 4'b0000, "R3 counting");
        cyc(0, e == 0, e == 1, 0, 4'b0000, "R3 exit no pulse");
        for (int i = 0; i < LONG + 1; i++) cyc(0, 0, 0, 1, 4'b0000, "R3 stays idle");
      end
    end

    // R4: exit input wins over grace tick
    for (int e = 0; e < 2; e++) begin
      arm();
      for (int i = 1; i < SHORT; i++) cyc(0, 0, 0, 1, 4'b0000, "R4 grace");
      cyc(0, e == 0, e == 1, 1, 4'b0000, "R4 exit beats timeout");
      for (int i = 0; i < LONG; i++) cyc(0, 0, 0, 1, 4'b0000, "R4 idle after tie");
    end

    // R5: exit from alarm at every tick position
    for (int e = 0; e < 2; e++) begin
      for (int m = SHORT; m < LONG; m++) begin
        to_alarm();
        for (int i = SHORT; i < m; i++) cyc(0, 0, 0, 1, 4'b0001, "R5 counting");
        cyc(0, e == 0, e == 1, 0, 4'b0010, "R5 exit alarm_off");
        cyc(0, 0, 0, 1, 4'b0000, "R5 idle");
      end
    end

    // R5: simultaneous exit input and final tick -> single pulse
    to_alarm();
    for (int i = SHORT + 1; i < LONG; i++) cyc(0, 0, 0, 1, 4'b0001, "R5 counting");
    cyc(0, 1, 1, 1, 4'b0010, "R5 tie single pulse");
    cyc(0, 0, 0, 0, 4'b0000, "R5 pulse one cycle");

    // R7: tick on start cycle not counted
    cyc(1, 0, 0, 1, 4'b1000, "R7 start with tick");
    for (int i = 1; i < SHORT; i++) cyc(0, 0, 0, 1, 4'b0000, "R7 tick not counted");
    cyc(0, 0, 0, 1, 4'b0101, "R7 alarm after full count");
    cyc(0, 0, 1, 0, 4'b0010, "R5 belt");

    // R6/R7: key_on in waiting does not restart
    arm();
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 4'b0000, "R6 counting");
    cyc(1, 0, 0, 0, 4'b0000, "R6 key_on ignored in wait");
    for (int i = 4; i < SHORT; i++) cyc(0, 0, 0, 1, 4'b0000, "R6 counting");
    cyc(0, 0, 0, 1, 4'b0101, "R6 no restart");

    // R1: reset in alarm
    do_reset();
    for (int i = 0; i < LONG; i++) cyc(0, 0, 0, 1, 4'b0000, "R1 idle after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule